// File: doc/BRIEF.md
# Paged Program and Data Address Region Decoder

This block takes one memory request from a processor core and decides which memory region it falls in. A data request carries a 16-bit word address. A program request carries the same 16-bit offset plus a 7-bit page number above it. The possible targets are the memory-mapped register window, the core's local dual-access RAM, its local single-access RAM, four shared program RAMs, a boot ROM and external memory. Five mode inputs steer the decode: overlay, data-space upper-half select, processor mode, ROM enable and the external-bus enable.

The result is registered. A request strobed on one rising edge gives a one-hot region select, a 13-bit offset inside an 8K-word block, a block index, the page driven to external memory and an error flag, all with a valid strobe after that edge. A small two-state controller, `IDLE` and `EMIT`, sequences the result. `IDLE` goes to `EMIT` on a request and stays in `IDLE` without one. `EMIT` stays in `EMIT` when a new request arrives in the same cycle and goes back to `IDLE` when none does. When no result is valid, all result outputs are zero.

Top module: `mmap_decoder`

## Requirements
- R1: In data space, addresses 0x0000–0x005F select the register window (region bit 0), and 0x0060–0x7FFF select dual-access RAM (region bit 1). Offset = addr[12:0]. Bank = 0 for the register window and {0, addr[14:13]} for the RAM.
- R2: In data space, 0x8000–0xFFFF selects single-access RAM (region bit 2, bank {0, addr[14:13]}) when the data-ROM select input is 1. When it is 0 and the external enable is 1, it selects external memory (region bit 8, bank addr[15:13]).
- R3: In program space, offsets 0x0000–0x7FFF in any page select dual-access RAM (bit 1, bank {0, addr[14:13]}) when overlay = 1. They select external memory when overlay = 0. With overlay = 1, offsets 0x0000–0x005F raise the error flag instead.
- R4: With processor mode = 0, in page 0, offsets 0x8000–0xDFFF select shared RAM 0 (bit 3, bank {0, addr[14:13]}). Offsets 0xE000–0xFFFF select ROM (bit 7, bank 0) when ROM enable = 1. When ROM enable = 0, they select dual-access RAM with bank 4.
- R5: With processor mode = 0, in pages 1, 2 and 3, offsets 0x8000–0xFFFF select shared RAM 1, 2 and 3 (bits 4, 5 and 6), with bank {0, addr[14:13]}.
- R6: With processor mode = 0, an upper-half program access to a page above 3 goes external. The external page output equals the page for pages 0–7. For pages 8–127 it equals 4 + page[1:0].
- R7: With processor mode = 1, an upper-half program access in any page goes external, with external page = page[1:0].
- R8: Any access that would go external while the external enable is 0 raises the error flag and selects no region. The external page output is 0 for every access that does not go external.
- R9: At most one region bit is set. When the error flag is set, no region bit is set and offset and bank are 0.
- R10: A request sampled on a rising edge makes the valid output high after that edge, carrying that request's result. Without a request, valid is low after the edge and all result outputs are 0.
- R11: During and right after reset, valid, region, error and the other result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe |
| is_prog | input | 1 | 1 = program space, 0 = data space |
| page | input | 7 | Program page number |
| addr | input | 16 | Word address or page offset |
| ovly | input | 1 | Overlay dual-access RAM into program space |
| drom | input | 1 | Data upper half goes to single-access RAM |
| mpmc | input | 1 | Processor mode: 1 = program upper half external |
| romen | input | 1 | Boot ROM enable in page 0 |
| xio | input | 1 | External bus enable |
| out_valid | output | 1 | Result valid |
| region_sel | output | 9 | One-hot region select |
| blk_off | output | 13 | Offset inside the 8K-word block |
| blk_bank | output | 3 | Block index inside the region |
| ext_page | output | 7 | Page driven to external memory |
| dec_err | output | 1 | Reserved or unreachable address |

## Verification
Two things can happen in the same cycle. The controller can capture a new request while it is still presenting the previous result, which is the `EMIT`-to-`EMIT` transition. The bench provokes this with back-to-back strobes whose mode inputs differ from one cycle to the next. A scoreboard queue checks that each result matches its own request in order, and that valid drops when a burst ends. In the same bursts, page folding and the external-enable error meet: a folded high page is sent once with the external enable set and once with it cleared, so the error must override the fold.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int ADDR_W = 16;
    localparam int BLK_W  = 13;
    localparam int BANK_W = ADDR_W - BLK_W;
    localparam int NREG   = 9;

    localparam int RG_MMR  = 0;
    localparam int RG_DAR  = 1;
    localparam int RG_SAR  = 2;
    localparam int RG_SHR0 = 3;
    localparam int RG_ROM  = 7;
    localparam int RG_EXT  = 8;

    localparam logic [ADDR_W-1:0] MMR_LAST = 16'h005F;
    localparam logic [ADDR_W-1:0] ROM_BASE = 16'hE000;
    localparam logic [BANK_W-1:0] DAR_EXTRA_BANK = 3'd4;

    typedef struct packed {
        logic [NREG-1:0]   region;
        logic              err;
        logic [BLK_W-1:0]  off;
        logic [BANK_W-1:0] bank;
    } dec_t;

endpackage

// File: rtl/mmap_data_dec.sv
module mmap_data_dec
    import mmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              drom,
    input  logic              xio,
    output dec_t              d
);
    always_comb begin
        d = '0;
        if (addr <= MMR_LAST) begin
            d.region[RG_MMR] = 1'b1;
            d.off            = addr[BLK_W-1:0];
        end else if (!addr[ADDR_W-1]) begin
            d.region[RG_DAR] = 1'b1;
            d.off            = addr[BLK_W-1:0];
            d.bank           = {1'b0, addr[ADDR_W-2:BLK_W]};
        end else if (drom) begin
            d.region[RG_SAR] = 1'b1;
            d.off            = addr[BLK_W-1:0];
            d.bank           = {1'b0, addr[ADDR_W-2:BLK_W]};
        end else if (xio) begin
            d.region[RG_EXT] = 1'b1;
            d.off            = addr[BLK_W-1:0];
            d.bank           = addr[ADDR_W-1:BLK_W];
        end else begin
            d.err = 1'b1;
        end
    end
endmodule

// File: rtl/mmap_page_fold.sv
module mmap_page_fold #(
    parameter int PAGE_W = 7
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              mpmc,
    output logic [PAGE_W-1:0] folded
);
    always_comb begin
        if (mpmc)
            folded = {{(PAGE_W-2){1'b0}}, page[1:0]};
        else if (|page[PAGE_W-1:3])
            folded = {{(PAGE_W-3){1'b0}}, 1'b1, page[1:0]};
        else
            folded = page;
    end
endmodule

// File: rtl/mmap_prog_dec.sv
module mmap_prog_dec
    import mmap_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    input  logic              ovly,
    input  logic              mpmc,
    input  logic              romen,
    input  logic              xio,
    output dec_t              d
);
    logic high_page;
    logic lower_half;

    assign high_page  = |page[PAGE_W-1:2];
    assign lower_half = !addr[ADDR_W-1];

    function automatic dec_t go_external(input logic [ADDR_W-1:0] a, input logic en);
        dec_t r;
        r = '0;
        if (en) begin
            r.region[RG_EXT] = 1'b1;
            r.off            = a[BLK_W-1:0];
            r.bank           = a[ADDR_W-1:BLK_W];
        end else begin
            r.err = 1'b1;
        end
        return r;
    endfunction

    always_comb begin
        d = '0;
        if (lower_half) begin
            if (!ovly) begin
                d = go_external(addr, xio);
            end else if (addr <= MMR_LAST) begin
                d.err = 1'b1;
            end else begin
                d.region[RG_DAR] = 1'b1;
                d.off            = addr[BLK_W-1:0];
                d.bank           = {1'b0, addr[ADDR_W-2:BLK_W]};
            end
        end else if (mpmc || high_page) begin
            d = go_external(addr, xio);
        end else if (page[1:0] == 2'd0 && addr >= ROM_BASE) begin
            d.off = addr[BLK_W-1:0];
            if (romen) begin
                d.region[RG_ROM] = 1'b1;
            end else begin
                d.region[RG_DAR] = 1'b1;
                d.bank           = DAR_EXTRA_BANK;
            end
        end else begin
            d.region[RG_SHR0 + int'(page[1:0])] = 1'b1;
            d.off  = addr[BLK_W-1:0];
            d.bank = {1'b0, addr[ADDR_W-2:BLK_W]};
        end
    end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              is_prog,
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ovly,
    input  logic              drom,
    input  logic              mpmc,
    input  logic              romen,
    input  logic              xio,
    output logic              out_valid,
    output logic [NREG-1:0]   region_sel,
    output logic [BLK_W-1:0]  blk_off,
    output logic [BANK_W-1:0] blk_bank,
    output logic [PAGE_W-1:0] ext_page,
    output logic              dec_err
);
    typedef enum logic [0:0] {IDLE = 1'b0, EMIT = 1'b1} state_t;

    state_t            state, nxt_state;
    dec_t              data_d, prog_d, sel_d, held_d;
    logic [PAGE_W-1:0] folded, sel_page, held_page;

    mmap_data_dec u_data (
        .addr (addr),
        .drom (drom),
        .xio  (xio),
        .d    (data_d)
    );

    mmap_prog_dec #(.PAGE_W(PAGE_W)) u_prog (
        .addr  (addr),
        .page  (page),
        .ovly  (ovly),
        .mpmc  (mpmc),
        .romen (romen),
        .xio   (xio),
        .d     (prog_d)
    );

    mmap_page_fold #(.PAGE_W(PAGE_W)) u_fold (
        .page   (page),
        .mpmc   (mpmc),
        .folded (folded)
    );

    always_comb begin
        sel_d    = is_prog ? prog_d : data_d;
        sel_page = (is_prog && sel_d.region[RG_EXT]) ? folded : '0;
    end

    always_comb begin
        unique case (state)
            IDLE:    nxt_state = req ? EMIT : IDLE;
            EMIT:    nxt_state = req ? EMIT : IDLE;
            default: nxt_state = IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IDLE;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_d    <= '0;
            held_page <= '0;
        end else if (req) begin
            held_d    <= sel_d;
            held_page <= sel_page;
        end
    end

    always_comb begin
        out_valid  = 1'b0;
        region_sel = '0;
        blk_off    = '0;
        blk_bank   = '0;
        ext_page   = '0;
        dec_err    = 1'b0;
        unique case (state)
            IDLE: ;
            EMIT: begin
                out_valid  = 1'b1;
                region_sel = held_d.region;
                blk_off    = held_d.off;
                blk_bank   = held_d.bank;
                ext_page   = held_page;
                dec_err    = held_d.err;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk
    import mmap_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              is_prog,
    input logic [PAGE_W-1:0] page,
    input logic [ADDR_W-1:0] addr,
    input logic              ovly,
    input logic              mpmc,
    input logic              romen,
    input logic              xio,
    input logic              out_valid,
    input logic [NREG-1:0]   region_sel,
    input logic [BANK_W-1:0] blk_bank,
    input logic              dec_err
);
    // R9
    one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel));

    // R9
    err_no_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (region_sel == '0));

    // R10
    req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> out_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!out_valid && region_sel == '0 && !dec_err));

    // R8
    no_ext_without_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !xio) |=> !region_sel[RG_EXT]);

    // R3
    overlay_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && is_prog && ovly && addr <= MMR_LAST) |=> dec_err);

    // R4
    extra_ram_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && is_prog && !mpmc && !romen && page == '0 && addr >= ROM_BASE)
        |=> (region_sel[RG_DAR] && blk_bank == DAR_EXTRA_BANK));
endmodule

bind mmap_decoder mmap_decoder_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .is_prog    (is_prog),
    .page       (page),
    .addr       (addr),
    .ovly       (ovly),
    .mpmc       (mpmc),
    .romen      (romen),
    .xio        (xio),
    .out_valid  (out_valid),
    .region_sel (region_sel),
    .blk_bank   (blk_bank),
    .dec_err    (dec_err)
);

// File: tb/mmap_decoder_bench.sv
module mmap_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        is_prog = 1'b0;
    logic [6:0]  page = '0;
    logic [15:0] addr = '0;
    logic        ovly = 1'b0, drom = 1'b0, mpmc = 1'b0, romen = 1'b1, xio = 1'b0;
    logic        out_valid;
    logic [8:0]  region_sel;
    logic [12:0] blk_off;
    logic [2:0]  blk_bank;
    logic [6:0]  ext_page;
    logic        dec_err;

    typedef struct {
        string       tag;
        logic [8:0]  region;
        logic        err;
        logic [12:0] off;
        logic [2:0]  bank;
        logic [6:0]  xpage;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    mmap_decoder u_mmap_decoder (
        .clk(clk), .rst_n(rst_n), .req(req), .is_prog(is_prog), .page(page),
        .addr(addr), .ovly(ovly), .drom(drom), .mpmc(mpmc), .romen(romen),
        .xio(xio), .out_valid(out_valid), .region_sel(region_sel),
        .blk_off(blk_off), .blk_bank(blk_bank), .ext_page(ext_page),
        .dec_err(dec_err)
    );

    function automatic exp_t model(string tag, logic p, logic [6:0] pg, logic [15:0] a,
                                   logic ov, logic dr, logic mp, logic ro, logic xi);
        exp_t e;
        int   kind;   // -1 error, else region bit index
        logic ext;
        e.tag = tag; e.region = '0; e.err = 0; e.off = '0; e.bank = '0; e.xpage = '0;
        kind = -1; ext = 0;
        if (!p) begin
            if (a < 16'h0060)      kind = 0;
            else if (a < 16'h8000) kind = 1;
            else if (dr)           kind = 2;
            else                   ext = 1;
        end else if (a < 16'h8000) begin
            if (!ov)               ext = 1;
            else if (a >= 16'h0060) kind = 1;
        end else if (mp || pg > 7'd3) begin
            ext = 1;
        end else if (pg == 7'd0 && a >= 16'hE000) begin
            kind = ro ? 7 : 1;
        end else begin
            kind = 3 + int'(pg);
        end
        if (ext && xi) kind = 8;
        if (kind < 0) begin
            e.err = 1;
            return e;
        end
        e.region[kind] = 1'b1;
        e.off = a[12:0];
        if (kind == 8) begin
            e.bank = a[15:13];
            if (p) e.xpage = mp ? {5'd0, pg[1:0]} : (pg >= 7'd8 ? 7'd4 + {5'd0, pg[1:0]} : pg);
        end else if (kind == 7 || kind == 0) e.bank = 3'd0;
        else if (kind == 1 && p && a >= 16'hE000) e.bank = 3'd4;
        else e.bank = {1'b0, a[14:13]};
        return e;
    endfunction

    task automatic send(string tag, logic p, logic [6:0] pg, logic [15:0] a,
                        logic ov, logic dr, logic mp, logic ro, logic xi);
        @(negedge clk);
        req = 1'b1; is_prog = p; page = pg; addr = a;
        ovly = ov; drom = dr; mpmc = mp; romen = ro; xio = xi;
        exp_q.push_back(model(tag, p, pg, a, ov, dr, mp, ro, xi));
    endtask

    task automatic rest(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req = 1'b0;
            addr = 16'hFFFF;
        end
    endtask

    // monitor: pops expected results as the design presents them
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                exp_t e;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R10: valid with no request pending, region %b expected none", region_sel);
                end else begin
                    e = exp_q.pop_front();
                    if (region_sel !== e.region || dec_err !== e.err || blk_off !== e.off ||
                        blk_bank !== e.bank || ext_page !== e.xpage) begin
                        fails++;
                        $display("FAIL %s: got region %b err %b off %h bank %0d xpage %0d, expected region %b err %b off %h bank %0d xpage %0d",
                                 e.tag, region_sel, dec_err, blk_off, blk_bank, ext_page,
                                 e.region, e.err, e.off, e.bank, e.xpage);
                    end
                end
            end else if (region_sel != '0 || dec_err || blk_off != '0 || ext_page != '0) begin
                checks++;
                fails++;
                $display("FAIL R10: idle outputs region %b err %b, expected zero", region_sel, dec_err);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        checks++;
        if (out_valid !== 1'b0 || region_sel !== '0 || dec_err !== 1'b0 || blk_bank !== '0) begin
            fails++;
            $display("FAIL R11: in reset valid %b region %b, expected 0 and 0", out_valid, region_sel);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || region_sel !== '0) begin
            fails++;
            $display("FAIL R11: after reset valid %b region %b, expected 0 and 0", out_valid, region_sel);
        end

        // R1 data lower half
        send("R1", 0, 7'd0, 16'h0000, 0, 0, 0, 1, 0);
        send("R1", 0, 7'd0, 16'h005F, 0, 0, 0, 1, 0);
        send("R1", 0, 7'd0, 16'h0060, 0, 0, 0, 1, 0);
        send("R1", 0, 7'd0, 16'h7FFF, 0, 0, 0, 1, 0);
        rest(2);
        // R2 data upper half
        send("R2", 0, 7'd0, 16'h8000, 0, 1, 0, 1, 0);
        send("R2", 0, 7'd0, 16'hC123, 0, 0, 0, 1, 1);
        send("R8", 0, 7'd0, 16'hC123, 0, 0, 0, 1, 0);
        rest(1);
        // R3 program lower half
        send("R3", 1, 7'd0, 16'h1234, 0, 0, 0, 1, 1);
        send("R3", 1, 7'd0, 16'h1234, 1, 0, 0, 1, 0);
        send("R3", 1, 7'd2, 16'h0010, 1, 0, 0, 1, 1);
        send("R8", 1, 7'd0, 16'h1234, 0, 0, 0, 1, 0);
        rest(1);
        // R4 page 0 upper half
        send("R4", 1, 7'd0, 16'h9000, 0, 0, 0, 1, 0);
        send("R4", 1, 7'd0, 16'hDFFF, 0, 0, 0, 1, 0);
        send("R4", 1, 7'd0, 16'hE000, 0, 0, 0, 1, 0);
        send("R4", 1, 7'd0, 16'hF00F, 0, 0, 0, 0, 0);
        rest(1);
        // R5 pages 1-3
        send("R5", 1, 7'd1, 16'h8001, 0, 0, 0, 1, 0);
        send("R5", 1, 7'd2, 16'hA000, 0, 0, 0, 1, 0);
        send("R5", 1, 7'd3, 16'hFFFF, 0, 0, 0, 1, 0);
        rest(2);
        // R6 high pages with processor mode 0, fold and bus error back to back
        send("R6", 1, 7'd5,  16'h8000, 0, 0, 0, 1, 1);
        send("R6", 1, 7'd74, 16'hB456, 0, 0, 0, 1, 1);
        send("R8", 1, 7'd74, 16'hB456, 0, 0, 0, 1, 0);
        send("R6", 1, 7'd127, 16'hFFFE, 0, 0, 0, 1, 1);
        rest(1);
        // R7 processor mode 1
        send("R7", 1, 7'd0,  16'h9000, 0, 0, 1, 1, 1);
        send("R7", 1, 7'd38, 16'hE000, 0, 0, 1, 1, 1);
        send("R3", 1, 7'd9,  16'h2000, 1, 0, 1, 1, 0);
        send("R8", 1, 7'd1,  16'h8000, 0, 0, 1, 1, 0);
        rest(3);
        // R9 error clears offset and bank
        send("R9", 0, 7'd0, 16'hFFFF, 0, 0, 0, 1, 0);
        rest(3);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10: %0d results never presented, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule